// File: doc/BRIEF.md
# Half-Duplex Line Turnaround Controller

This block sits beside a UART transmitter and receiver that share one half-duplex line. It decides the line direction. It drives the enable input of an RS-485 line driver and grants the transmitter permission to start. It blanks the receiver while the block owns the line for transmit. An optional guard of four character times can be placed before transmission starts, after the transmitter goes quiet, or both. The guard suits infrared transceivers that need settling time after a direction change. The block also applies programmable polarity to the infrared receive and transmit lines.

A seven-bit configuration register is loaded through a write strobe. A four-state machine tracks the line direction:
- `ST_RX_IDLE`: the line is in receive.
- `ST_TX_GUARD`: the block is waiting out the guard before transmit.
- `ST_TX_ACTIVE`: the transmitter may shift.
- `ST_RX_GUARD`: the receiver is still blanked after transmit.

The transitions are:
- `ST_RX_IDLE` goes to `ST_TX_GUARD` on pending data with the transmit guard on, or straight to `ST_TX_ACTIVE` with it off.
- `ST_TX_GUARD` goes to `ST_TX_ACTIVE` when the guard timer reaches zero.
- `ST_TX_ACTIVE` goes to `ST_RX_GUARD` once the FIFO is empty and the shifter is idle, with the receive guard on, or to `ST_RX_IDLE` with it off.
- `ST_RX_GUARD` goes to `ST_RX_IDLE` when the timer reaches zero.

One character time is the frame length in bits multiplied by 16 baud ticks.

Top module: `hdx_turnaround`

## Requirements
- R1: After reset the configuration is 7'b001_0000: only the IR half-duplex bit (bit 4) is set. The state is `ST_RX_IDLE`, `tx_permit` is 0 and `rx_enable` is 1.
- R2: With the transmit-guard bit (bit 0) clear, `tx_permit` rises on the clock edge that samples `tx_fifo_empty` low in `ST_RX_IDLE`.
- R3: With bit 0 set, `tx_permit` rises N+1 edges after that edge, where N = 64 × `frame_bits` and one baud tick arrives per clock.
- R4: With the receive-guard bit (bit 1) clear, `rx_enable` returns on the edge that samples `tx_fifo_empty` high and `tx_busy` low in `ST_TX_ACTIVE`.
- R5: With bit 1 set, `rx_enable` returns N+1 edges after that edge.
- R6: With automatic control (bit 2) set and invert (bit 3) clear, `de_pin` is 1 in `ST_TX_GUARD` and `ST_TX_ACTIVE` and 0 otherwise. It stays 1 while `tx_busy` is high.
- R7: With bits 2 and 3 both set, `de_pin` is the inverse of the R6 value.
- R8: With bit 2 clear, `de_pin` equals `manual_de`.
- R9: With bit 4 clear (full duplex), `rx_enable` is 1 in every state. With bit 4 set, `rx_enable` is 1 only in `ST_RX_IDLE`.
- R10: `ir_rx` is `ir_rx_raw` XOR bit 5, and `ir_tx_pin` is `ir_tx_raw` XOR bit 6.
- R11: `rx_strobe_out` and `rx_err_out` are their inputs ANDed with `rx_enable`. Bytes received while blanked are dropped without an error flag.
- R12: The guard counter changes only on cycles with `baud_tick` high. A stall in baud ticks lengthens the guard by the stall length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | 16x oversampling baud tick |
| frame_bits | input | 4 | Bits per frame (start+data+parity+stop) |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| tx_busy | input | 1 | Transmit shifter is sending |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration value |
| manual_de | input | 1 | Manual driver-enable level |
| rx_strobe_in | input | 1 | Receiver byte-done strobe |
| rx_err_in | input | 1 | Receiver error flag |
| ir_rx_raw | input | 1 | Infrared receive line from transceiver |
| ir_tx_raw | input | 1 | Infrared transmit data from shifter |
| de_pin | output | 1 | RS-485 driver enable |
| tx_permit | output | 1 | Transmitter may start shifting |
| rx_enable | output | 1 | Receiver enabled |
| rx_strobe_out | output | 1 | Gated byte-done strobe |
| rx_err_out | output | 1 | Gated error flag |
| ir_rx | output | 1 | Polarity-adjusted IR receive |
| ir_tx_pin | output | 1 | Polarity-adjusted IR transmit |

## Verification
The hardest situation to reach is a baud-tick stall in the middle of a guard interval. The timer must freeze without losing its count, and that can only be seen from the ports as a late rise of `tx_permit`. The stimulus starts a guarded turnaround and withholds ticks for a fixed number of cycles partway through. It then checks that the permit edge moves by exactly that amount. Random configuration values are also written while the block sits in `ST_TX_ACTIVE`, so that the blanking, gating and pin polarity are checked in the transmit direction and not only at rest.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
    typedef enum logic [1:0] {
        ST_RX_IDLE   = 2'd0,
        ST_TX_GUARD  = 2'd1,
        ST_TX_ACTIVE = 2'd2,
        ST_RX_GUARD  = 2'd3
    } hdx_state_t;

    typedef struct packed {
        logic irtx_inv;   // bit 6
        logic irrx_inv;   // bit 5
        logic ir_half;    // bit 4
        logic de_invert;  // bit 3
        logic auto_de;    // bit 2
        logic rx_guard;   // bit 1
        logic tx_guard;   // bit 0
    } hdx_cfg_t;

    localparam hdx_cfg_t CFG_RESET = 7'b001_0000;
endpackage

// File: rtl/hdx_guard_timer.sv
module hdx_guard_timer #(
    parameter int FRAME_W    = 4,
    parameter int OVERSAMPLE = 16,
    parameter int GUARD_CHARS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               tick,
    input  logic [FRAME_W-1:0] frame_bits,
    output logic               done
);
    localparam int GUARD_MUL = OVERSAMPLE * GUARD_CHARS;
    localparam int CNT_W     = FRAME_W + $clog2(GUARD_MUL);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    assign load_val = CNT_W'(frame_bits) * CNT_W'(GUARD_MUL);
    assign done     = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R12: without a tick or a load the count holds
    p_cnt_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt));
    // R3: an expired guard never wraps
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && done) |=> done);
endmodule

// File: rtl/hdx_turn_fsm.sv
module hdx_turn_fsm
    import hdx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  hdx_cfg_t cfg,
    input  logic     tx_fifo_empty,
    input  logic     tx_busy,
    input  logic     guard_done,
    output logic     guard_load,
    output logic     tx_permit,
    output logic     line_tx,
    output logic     rx_blank
);
    hdx_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx   = state;
        guard_load = 1'b0;
        unique case (state)
            ST_RX_IDLE: begin
                if (!tx_fifo_empty) begin
                    if (cfg.tx_guard) begin
                        guard_load = 1'b1;
                        state_nx   = ST_TX_GUARD;
                    end else begin
                        state_nx   = ST_TX_ACTIVE;
                    end
                end
            end
            ST_TX_GUARD: begin
                if (guard_done) state_nx = ST_TX_ACTIVE;
            end
            ST_TX_ACTIVE: begin
                if (tx_fifo_empty && !tx_busy) begin
                    if (cfg.rx_guard) begin
                        guard_load = 1'b1;
                        state_nx   = ST_RX_GUARD;
                    end else begin
                        state_nx   = ST_RX_IDLE;
                    end
                end
            end
            ST_RX_GUARD: begin
                if (guard_done) state_nx = ST_RX_IDLE;
            end
            default: state_nx = ST_RX_IDLE;
        endcase
    end

    always_comb begin
        tx_permit = (state == ST_TX_ACTIVE);
        line_tx   = (state == ST_TX_GUARD) || (state == ST_TX_ACTIVE);
        rx_blank  = (state != ST_RX_IDLE);
    end

    // R6: transmit direction is left only with an empty FIFO and idle shifter
    p_leave_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_tx) |-> ($past(tx_fifo_empty) && !$past(tx_busy)));
    // R3: a guarded permit edge comes only from an expired timer
    p_permit_after_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_permit) && $past(state) == ST_TX_GUARD) |-> $past(guard_done));
endmodule

// File: rtl/hdx_pin_drive.sv
module hdx_pin_drive
    import hdx_pkg::*;
(
    input  hdx_cfg_t cfg,
    input  logic     line_tx,
    input  logic     rx_blank,
    input  logic     manual_de,
    input  logic     rx_strobe_in,
    input  logic     rx_err_in,
    input  logic     ir_rx_raw,
    input  logic     ir_tx_raw,
    output logic     de_pin,
    output logic     rx_enable,
    output logic     rx_strobe_out,
    output logic     rx_err_out,
    output logic     ir_rx,
    output logic     ir_tx_pin
);
    always_comb begin
        de_pin        = cfg.auto_de ? (line_tx ^ cfg.de_invert) : manual_de;
        rx_enable     = !cfg.ir_half || !rx_blank;
        rx_strobe_out = rx_strobe_in && rx_enable;
        rx_err_out    = rx_err_in && rx_enable;
        ir_rx         = ir_rx_raw ^ cfg.irrx_inv;
        ir_tx_pin     = ir_tx_raw ^ cfg.irtx_inv;
    end

    // R11: nothing passes to the receiver side while blanked
    p_rx_gate_r11: assert final (!(rx_strobe_out || rx_err_out) || rx_enable);
    // R9: full duplex never blanks
    p_full_duplex_r9: assert final (cfg.ir_half || rx_enable);
endmodule

// File: rtl/hdx_turnaround.sv
module hdx_turnaround
    import hdx_pkg::*;
#(
    parameter int FRAME_W     = 4,
    parameter int OVERSAMPLE  = 16,
    parameter int GUARD_CHARS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               baud_tick,
    input  logic [FRAME_W-1:0] frame_bits,
    input  logic               tx_fifo_empty,
    input  logic               tx_busy,
    input  logic               cfg_wr,
    input  logic [6:0]         cfg_wdata,
    input  logic               manual_de,
    input  logic               rx_strobe_in,
    input  logic               rx_err_in,
    input  logic               ir_rx_raw,
    input  logic               ir_tx_raw,
    output logic               de_pin,
    output logic               tx_permit,
    output logic               rx_enable,
    output logic               rx_strobe_out,
    output logic               rx_err_out,
    output logic               ir_rx,
    output logic               ir_tx_pin
);
    hdx_cfg_t cfg;
    logic     guard_load, guard_done, line_tx, rx_blank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg <= CFG_RESET;
        else if (cfg_wr) cfg <= hdx_cfg_t'(cfg_wdata);
    end

    hdx_guard_timer #(
        .FRAME_W(FRAME_W), .OVERSAMPLE(OVERSAMPLE), .GUARD_CHARS(GUARD_CHARS)
    ) timer_i (
        .clk(clk), .rst_n(rst_n), .load(guard_load), .tick(baud_tick),
        .frame_bits(frame_bits), .done(guard_done)
    );

    hdx_turn_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .tx_fifo_empty(tx_fifo_empty),
        .tx_busy(tx_busy), .guard_done(guard_done), .guard_load(guard_load),
        .tx_permit(tx_permit), .line_tx(line_tx), .rx_blank(rx_blank)
    );

    hdx_pin_drive pins_i (
        .cfg(cfg), .line_tx(line_tx), .rx_blank(rx_blank), .manual_de(manual_de),
        .rx_strobe_in(rx_strobe_in), .rx_err_in(rx_err_in),
        .ir_rx_raw(ir_rx_raw), .ir_tx_raw(ir_tx_raw), .de_pin(de_pin),
        .rx_enable(rx_enable), .rx_strobe_out(rx_strobe_out),
        .rx_err_out(rx_err_out), .ir_rx(ir_rx), .ir_tx_pin(ir_tx_pin)
    );

    // R6: automatic non-inverted enable drops only after the shifter drains
    p_de_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.auto_de && $past(cfg.auto_de) && !cfg.de_invert
         && !$past(cfg.de_invert) && $fell(de_pin))
        |-> ($past(tx_fifo_empty) && !$past(tx_busy)));
    // R9: in half duplex the receiver is off whenever transmit is granted
    p_rx_off_in_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.ir_half && tx_permit) |-> !rx_enable);
endmodule

// File: tb/hdx_turnaround_tb_top.sv
`timescale 1ns/1ps
module hdx_turnaround_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic [3:0] frame_bits = 4'd10;
    logic       tx_fifo_empty = 1'b1, tx_busy = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       manual_de = 1'b0, rx_strobe_in = 1'b0, rx_err_in = 1'b0;
    logic       ir_rx_raw = 1'b0, ir_tx_raw = 1'b0;
    logic       de_pin, tx_permit, rx_enable, rx_strobe_out, rx_err_out, ir_rx, ir_tx_pin;

    int n_chk = 0;
    int n_bad = 0;
    logic [6:0] cur_cfg = 7'b001_0000;

    always #2 clk = ~clk;

    hdx_turnaround dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .frame_bits(frame_bits),
        .tx_fifo_empty(tx_fifo_empty), .tx_busy(tx_busy), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .manual_de(manual_de), .rx_strobe_in(rx_strobe_in),
        .rx_err_in(rx_err_in), .ir_rx_raw(ir_rx_raw), .ir_tx_raw(ir_tx_raw),
        .de_pin(de_pin), .tx_permit(tx_permit), .rx_enable(rx_enable),
        .rx_strobe_out(rx_strobe_out), .rx_err_out(rx_err_out),
        .ir_rx(ir_rx), .ir_tx_pin(ir_tx_pin)
    );

    function automatic logic exp_de(logic [6:0] c, logic man, logic txdir);
        return c[2] ? (txdir ^ c[3]) : man;
    endfunction

    function automatic logic exp_rxen(logic [6:0] c, logic blank);
        return !c[4] || !blank;
    endfunction

    function automatic int guard_edges(logic [3:0] fb);
        return 64 * int'(fb) + 2;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(logic [6:0] v);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        cur_cfg = v;
    endtask

    task automatic tx_on(output int k);
        tx_fifo_empty = 1'b0;
        k = 0;
        while (k < 5000) begin
            @(posedge clk); #1;
            k++;
            if (tx_permit) break;
        end
    endtask

    task automatic tx_off(output int k);
        tx_busy = 1'b1; tx_fifo_empty = 1'b1;
        repeat (3) begin
            @(posedge clk); #1;
        end
        chk("R6 busy holds direction", int'(de_pin), int'(exp_de(cur_cfg, manual_de, 1'b1)));
        tx_busy = 1'b0;
        k = 0;
        while (k < 5000) begin
            @(posedge clk); #1;
            k++;
            if (rx_enable) break;
        end
    endtask

    task automatic rand_pins(logic txdir);
        logic [6:0] v;
        v = 7'($urandom);
        v[1:0] = 2'b00;
        write_cfg(v);
        manual_de = 1'($urandom); rx_strobe_in = 1'($urandom); rx_err_in = 1'($urandom);
        ir_rx_raw = 1'($urandom); ir_tx_raw = 1'($urandom);
        #1;
        chk("R6/R7/R8 de_pin", int'(de_pin), int'(exp_de(v, manual_de, txdir)));
        chk("R9 rx_enable", int'(rx_enable), int'(exp_rxen(v, txdir)));
        chk("R11 strobe gate", int'(rx_strobe_out), int'(rx_strobe_in && exp_rxen(v, txdir)));
        chk("R11 error gate", int'(rx_err_out), int'(rx_err_in && exp_rxen(v, txdir)));
        chk("R10 ir_rx", int'(ir_rx), int'(ir_rx_raw ^ v[5]));
        chk("R10 ir_tx_pin", int'(ir_tx_pin), int'(ir_tx_raw ^ v[6]));
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k;
        logic [3:0] fb;
        void'($urandom(32'd4711));
        ir_rx_raw = 1'b1; ir_tx_raw = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 tx_permit", int'(tx_permit), 0);
        chk("R1 rx_enable", int'(rx_enable), 1);
        chk("R1 de manual", int'(de_pin), 0);
        chk("R1 ir_rx plain", int'(ir_rx), 1);
        chk("R1 ir_tx plain", int'(ir_tx_pin), 1);

        // R2 immediate turnaround, defaults untouched (half duplex on)
        manual_de = 1'b1;
        tx_on(k);
        chk("R2 permit edge", k, 1);
        chk("R1 half-duplex default blanks", int'(rx_enable), 0);
        chk("R8 manual de in tx", int'(de_pin), 1);
        manual_de = 1'b0; #1;
        chk("R8 manual de low", int'(de_pin), 0);
        rx_strobe_in = 1'b1; rx_err_in = 1'b1; #1;
        chk("R11 strobe dropped", int'(rx_strobe_out), 0);
        chk("R11 error dropped", int'(rx_err_out), 0);
        rx_strobe_in = 1'b0; rx_err_in = 1'b0;
        tx_off(k);
        chk("R4 rx return edge", k, 1);

        // R6 automatic enable
        write_cfg(7'b001_0100);
        tx_on(k);
        chk("R6 de in tx", int'(de_pin), 1);
        tx_off(k);
        chk("R6 de after tx", int'(de_pin), 0);

        // R7 inverted
        write_cfg(7'b001_1100);
        #1 chk("R7 de idle inverted", int'(de_pin), 1);
        tx_on(k);
        chk("R7 de tx inverted", int'(de_pin), 0);
        tx_off(k);

        // R3 transmit guard, several frame lengths
        write_cfg(7'b001_0101);
        for (int i = 0; i < 3; i++) begin
            fb = (i == 0) ? 4'd10 : 4'(5 + ($urandom % 8));
            frame_bits = fb;
            tx_fifo_empty = 1'b0;
            @(posedge clk); #1;
            chk("R6 de during guard", int'(de_pin), 1);
            chk("R3 no permit in guard", int'(tx_permit), 0);
            k = 1;
            while (k < 5000) begin
                @(posedge clk); #1;
                k++;
                if (tx_permit) break;
            end
            chk("R3 guard length", k, guard_edges(fb));
            tx_off(k);
            chk("R4 rx return no rx guard", k, 1);
        end

        // R5 receive guard
        frame_bits = 4'd7;
        write_cfg(7'b001_0110);
        tx_on(k);
        tx_off(k);
        chk("R5 rx guard length", k, guard_edges(4'd7));

        // R12 tick stall inside the guard
        frame_bits = 4'd5;
        write_cfg(7'b001_0101);
        tx_fifo_empty = 1'b0;
        k = 0;
        while (k < 5000) begin
            @(posedge clk); #1;
            k++;
            if (k == 10)  baud_tick = 1'b0;
            if (k == 110) baud_tick = 1'b1;
            if (k == 100) chk("R12 stalled no permit", int'(tx_permit), 0);
            if (tx_permit) break;
        end
        chk("R12 stall extends guard", k, guard_edges(4'd5) + 100);
        tx_off(k);

        // R9 full duplex keeps receiver on
        write_cfg(7'b000_0100);
        tx_on(k);
        chk("R9 full duplex rx in tx", int'(rx_enable), 1);

        // random pin checks in transmit direction, then at rest
        for (int i = 0; i < 60; i++) rand_pins(1'b1);
        write_cfg(7'b001_0000);
        tx_off(k);
        for (int i = 0; i < 60; i++) rand_pins(1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule